// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block forms the status word that a non-volatile memory returns on reads while an embedded program or erase runs inside it. The sequencer that drives the operation supplies a busy indication, the kind of operation, a suspend state, a time-limit flag, an erase-started flag, the bank being worked on, the byte being programmed and the set of blocks chosen for erase. On every qualified read the block decides whether the read targets the busy region. If it does, the block returns a status byte built from polling, toggle, timeout and phase flags. If it does not, array data passes through unchanged.

The two toggle flags are held in their own flip-flops and advance only on read strobes, not on clock cycles. So software that reads twice sees whether the operation is still running, whatever the interval between the reads. A registered ready/busy output follows the busy input one cycle later.

Top module: `status_flag_gen`

## Requirements
- R1: After reset readyBusy is 1. While opBusy is 0 every read returns arrayData unchanged, and neither toggle flag advances.
- R2: In the status word, bit 7 is the inverse of progData[7] during a program and 0 during an erase.
- R3: Bit 6 of the status word inverts on each successive status read while the operation is not suspended. The first status read after reset returns 0.
- R4: While opSuspended is 1, status reads leave bit 6 unchanged. After opSuspended returns to 0, bit 6 toggles on reads again.
- R5: The toggle flags keep their last value across idle periods. The next operation starts from that value.
- R6: During an erase, bit 2 inverts on each status read addressed to a block whose eraseSel bit is 1. When chipErase is 1, every block counts as selected and every bank counts as busy. Bit 2 also toggles while the erase is suspended. During a program, bit 2 holds its value.
- R7: A read of an unselected block in the busy bank returns the status word but leaves bit 2 unchanged.
- R8: A read whose bank (readBlock divided by BLOCKS_PER_BANK) differs from opBank, when chipErase is 0, returns arrayData, and neither toggle flag advances.
- R9: Bit 5 of the status word equals timeLimitHit.
- R10: Bit 3 of the status word equals eraseStarted during an erase and is 0 during a program.
- R11: readyBusy equals the inverse of opBusy delayed by one clock.
- R12: Bits 15:8, bit 4 and bits 1:0 of the status word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opBusy | input | 1 | Embedded operation in progress |
| opIsErase | input | 1 | 1 = erase, 0 = program |
| opSuspended | input | 1 | Operation suspended |
| chipErase | input | 1 | Erase covers every block |
| eraseStarted | input | 1 | Erase hold window over, erasure begun |
| timeLimitHit | input | 1 | Operation exceeded its time limit |
| opBank | input | BANK_W | Bank holding the operation target |
| progData | input | 8 | Low byte of data being programmed |
| eraseSel | input | NUM_BLOCKS | Blocks selected for erase |
| readStrobe | input | 1 | Qualified read, one cycle |
| readBlock | input | BLK_W | Block index of the read address |
| arrayData | input | DATA_W | Array read data |
| rdData | output | DATA_W | Read data returned to the host |
| readyBusy | output | 1 | 1 = ready, 0 = busy |

## Verification
A single read strobe can advance both toggle flags in the same cycle. This happens during an unsuspended erase when the read hits a selected block. Suspension is where the two paths part: bit 2 must still advance while bit 6 freezes. The bench provokes both cases by reading the same selected block before, during and after a suspend. For each read it predicts both toggle bits from its own model and compares the whole returned word.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;
  typedef struct packed {
    logic statusSel;  // read hits the busy region
    logic flip6;      // advance the operation toggle
    logic flip2;      // advance the block toggle
  } flag_strobes_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_gen_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BLOCKS_PER_BANK = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int NUM_BANKS = NUM_BLOCKS / BLOCKS_PER_BANK,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  opBusy,
  input  logic                  opIsErase,
  input  logic                  opSuspended,
  input  logic                  chipErase,
  input  logic [BANK_W-1:0]     opBank,
  input  logic [NUM_BLOCKS-1:0] eraseSel,
  input  logic                  readStrobe,
  input  logic [BLK_W-1:0]      readBlock,
  output flag_strobes_t         strobes,
  output logic                  readyBusy
);
  logic [NUM_BLOCKS-1:0] blkBusy;
  logic [NUM_BLOCKS-1:0] blkSel;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    localparam int BANK_OF = b / BLOCKS_PER_BANK;
    always_comb begin
      blkBusy[b] = opBusy && ((opIsErase && chipErase) || (BANK_W'(BANK_OF) == opBank));
      blkSel[b]  = opIsErase && (chipErase || eraseSel[b]);
    end
  end

  always_comb begin
    strobes.statusSel = blkBusy[readBlock];
    strobes.flip6     = readStrobe && strobes.statusSel && !opSuspended;
    strobes.flip2     = readStrobe && strobes.statusSel && blkSel[readBlock];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) readyBusy <= 1'b1;
    else        readyBusy <= !opBusy;
  end

  assert_ready_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    opBusy |=> !readyBusy);
  assert_ready_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !opBusy |=> readyBusy);
  assert_idle_noflip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !opBusy |-> !(strobes.flip6 || strobes.flip2));
  assert_suspend_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    opSuspended |-> !strobes.flip6);
  assert_unsel_noflip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!chipErase && !eraseSel[readBlock]) |-> !strobes.flip2);
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_gen_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  flag_strobes_t     strobes,
  input  logic              opIsErase,
  input  logic              eraseStarted,
  input  logic              timeLimitHit,
  input  logic [7:0]        progData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);
  logic toggle6;
  logic toggle2;
  logic [7:0] statusByte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggle6 <= 1'b0;
      toggle2 <= 1'b0;
    end else begin
      if (strobes.flip6) toggle6 <= !toggle6;
      if (strobes.flip2) toggle2 <= !toggle2;
    end
  end

  always_comb begin
    statusByte    = '0;
    statusByte[7] = opIsErase ? 1'b0 : !progData[7];
    statusByte[6] = toggle6;
    statusByte[5] = timeLimitHit;
    statusByte[3] = opIsErase && eraseStarted;
    statusByte[2] = toggle2;
    rdData = strobes.statusSel ? DATA_W'(statusByte) : arrayData;
  end

  assert_dq6_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.flip6 |=> toggle6 != $past(toggle6));
  assert_dq6_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.flip6 |=> $stable(toggle6));
  assert_dq2_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.flip2 |=> toggle2 != $past(toggle2));
  assert_dq2_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.flip2 |=> $stable(toggle2));
endmodule

// File: rtl/status_flag_gen.sv
module status_flag_gen
  import flag_gen_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BLOCKS_PER_BANK = 4,
  parameter int DATA_W = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int NUM_BANKS = NUM_BLOCKS / BLOCKS_PER_BANK,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  opBusy,
  input  logic                  opIsErase,
  input  logic                  opSuspended,
  input  logic                  chipErase,
  input  logic                  eraseStarted,
  input  logic                  timeLimitHit,
  input  logic [BANK_W-1:0]     opBank,
  input  logic [7:0]            progData,
  input  logic [NUM_BLOCKS-1:0] eraseSel,
  input  logic                  readStrobe,
  input  logic [BLK_W-1:0]      readBlock,
  input  logic [DATA_W-1:0]     arrayData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  readyBusy
);
  flag_strobes_t strobes;

  flag_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCKS_PER_BANK(BLOCKS_PER_BANK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .opBusy(opBusy), .opIsErase(opIsErase),
    .opSuspended(opSuspended), .chipErase(chipErase), .opBank(opBank),
    .eraseSel(eraseSel), .readStrobe(readStrobe), .readBlock(readBlock),
    .strobes(strobes), .readyBusy(readyBusy)
  );

  flag_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .opIsErase(opIsErase),
    .eraseStarted(eraseStarted), .timeLimitHit(timeLimitHit),
    .progData(progData), .arrayData(arrayData), .rdData(rdData)
  );
endmodule

// File: tb/status_flag_gen_tb.sv
module status_flag_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int BPB = 4;

  logic clk = 0, rst_n = 0;
  logic opBusy = 0, opIsErase = 0, opSuspended = 0, chipErase = 0;
  logic eraseStarted = 0, timeLimitHit = 0;
  logic [1:0] opBank = 0;
  logic [7:0] progData = 0;
  logic [NB-1:0] eraseSel = 0;
  logic readStrobe = 0;
  logic [3:0] readBlock = 0;
  logic [15:0] arrayData = 0;
  logic [15:0] rdData;
  logic readyBusy;

  int checks = 0, fails = 0;
  bit done = 0;
  logic m6 = 0, m2 = 0;
  logic [15:0] expQ[$];
  string tagQ[$];

  status_flag_gen u_dut (
    .clk(clk), .rst_n(rst_n), .opBusy(opBusy), .opIsErase(opIsErase),
    .opSuspended(opSuspended), .chipErase(chipErase), .eraseStarted(eraseStarted),
    .timeLimitHit(timeLimitHit), .opBank(opBank), .progData(progData),
    .eraseSel(eraseSel), .readStrobe(readStrobe), .readBlock(readBlock),
    .arrayData(arrayData), .rdData(rdData), .readyBusy(readyBusy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // driver: predict the word for this read, queue it, then strobe
  task automatic doRead(input int blk, input string tag);
    logic inBusy, sel;
    logic [15:0] e;
    inBusy = opBusy && ((opIsErase && chipErase) || (blk / BPB == int'(opBank)));
    sel = opIsErase && (chipErase || eraseSel[blk]);
    arrayData = 16'hA5C3 ^ 16'(blk * 16'h0111);
    if (inBusy) e = {8'h00, (opIsErase ? 1'b0 : ~progData[7]), m6, timeLimitHit, 1'b0,
                     (opIsErase & eraseStarted), m2, 2'b00};
    else        e = arrayData;
    expQ.push_back(e);
    tagQ.push_back(tag);
    if (inBusy && !opSuspended) m6 = ~m6;
    if (inBusy && sel) m2 = ~m2;
    readBlock = 4'(blk);
    readStrobe = 1;
    @(posedge clk); #1;
    readStrobe = 0;
  endtask

  // monitor: compare away from the edge
  always @(negedge clk) begin
    if (readStrobe && expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData !== e) begin
        fails++;
        $display("FAIL %s: rdData=%h expected=%h", t, rdData, e);
      end
    end
  end

  task automatic checkRb(input logic e, input string tag);
    @(posedge clk); @(negedge clk);
    checks++;
    if (readyBusy !== e) begin
      fails++;
      $display("FAIL %s: readyBusy=%b expected=%b", tag, readyBusy, e);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: timeout expired expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state and idle passthrough
    @(negedge clk);
    checks++;
    if (readyBusy !== 1'b1) begin fails++; $display("FAIL R1: readyBusy=%b expected=1", readyBusy); end
    @(posedge clk); #1;
    doRead(5, "R1 idle");
    // program in bank 1
    opBank = 2'd1; opIsErase = 0; progData = 8'h80; eraseStarted = 1;
    opBusy = 1;
    checkRb(1'b0, "R11 busy");
    doRead(4, "R2 R3 R12 prog first");
    doRead(4, "R3 prog second");
    doRead(6, "R3 R10 prog third");
    doRead(9, "R8 other bank");
    progData = 8'h3C;
    doRead(7, "R2 inverted bit7");
    timeLimitHit = 1;
    doRead(5, "R9 timeout");
    timeLimitHit = 0;
    opSuspended = 1;
    doRead(5, "R4 suspended");
    doRead(5, "R4 suspended again");
    opSuspended = 0;
    doRead(5, "R4 resumed");
    opBusy = 0;
    checkRb(1'b1, "R11 ready");
    doRead(4, "R5 idle after prog");
    // erase in bank 2, block 9 selected
    opIsErase = 1; opBank = 2'd2; eraseSel = 16'h0200; eraseStarted = 0;
    opBusy = 1;
    doRead(9, "R5 R6 R10 erase hold");
    eraseStarted = 1;
    doRead(9, "R6 R10 erase running");
    doRead(10, "R7 unselected same bank");
    doRead(11, "R7 unselected again");
    opSuspended = 1;
    doRead(9, "R4 R6 suspended erase");
    doRead(9, "R4 R6 suspended erase again");
    opSuspended = 0;
    doRead(9, "R4 erase resumed");
    doRead(1, "R8 erase other bank");
    // chip erase covers all
    chipErase = 1; eraseSel = 0;
    doRead(14, "R6 chip erase far block");
    doRead(0, "R6 chip erase block0");
    timeLimitHit = 1;
    doRead(3, "R9 R6 chip timeout");
    opBusy = 0; chipErase = 0; timeLimitHit = 0;
    checkRb(1'b1, "R11 ready after erase");
    doRead(2, "R1 idle end");
    @(posedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule